// File: doc/BRIEF.md
# Programmable Sum-of-Products Array

This block is the AND-OR plane of a small programmable logic cell. Twelve dedicated inputs and ten feedback lines from downstream output cells form twenty-two signals. Each signal appears in true and inverted form, giving forty-four columns. Every product-term row holds a forty-four-bit connection mask and one enable bit. The row is the AND of the columns its mask selects, gated by its enable. Rows are gathered into ten OR sums of unequal size (8, 10, 12, 14, 16, 16, 14, 12, 10 and 8 terms). The plane also produces one output-enable term per output and two shared terms, an asynchronous reset and a synchronous preset, meant for the output registers.

Rows are loaded one at a time through a valid/ready configuration port. The block never applies back-pressure outside reset: `cfg_ready` is low only while `rst` is high, and a beat counts as accepted on any rising edge where `cfg_valid` and `cfg_ready` are both high. Evaluation is purely combinational from the inputs and the stored rows. A row written at an edge therefore shapes the outputs from just after that edge.

Top module: `pal_sop_array`

## Requirements
- R1: Column 2*i carries signal i true and column 2*i+1 carries it inverted, where signals 0..11 are `ded_in[0..11]` and signals 12..21 are `fb_in[0..9]`. An enabled row is 1 exactly when every column set in its mask is 1.
- R2: An enabled row whose mask is all zero evaluates to 1.
- R3: A row whose mask sets both the true and the inverted column of one signal evaluates to 0 for every input pattern.
- R4: A row whose enable bit is 0 evaluates to 0 whatever its mask holds.
- R5: Sum k (`sum_out[k]`) is the OR of rows base(k) to base(k)+size(k)-1. The sizes are 8,10,12,14,16,16,14,12,10,8 for k=0..9, and base(k) is the total of the sizes before k (rows 0..119 in all).
- R6: `oe_out[k]` equals row 120+k, and no sum uses that row.
- R7: `arst_term` equals row 130 and `spre_term` equals row 131, and no sum or enable uses either row.
- R8: An accepted beat stores `cfg_mask` and `cfg_term_en` into row `cfg_addr`, replacing the row's old contents. The outputs keep using the old row until that edge and the new row after it.
- R9: A beat whose `cfg_addr` is 132 or above changes no row.
- R10: While `rst` is high, `cfg_ready` is 0 and every row is cleared, so that all outputs read 0 after reset. Outside reset `cfg_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration rows |
| rst | input | 1 | Synchronous active-high reset, clears all rows |
| ded_in | input | 12 | Dedicated array inputs, signals 0..11 |
| fb_in | input | 10 | Feedback lines, signals 12..21 |
| cfg_valid | input | 1 | Configuration beat present |
| cfg_ready | output | 1 | Configuration beat can be taken |
| cfg_addr | input | 8 | Row index of the beat |
| cfg_mask | input | 44 | Column connection mask of the row |
| cfg_term_en | input | 1 | Enable bit of the row |
| sum_out | output | 10 | OR sums, one per output |
| oe_out | output | 10 | Output-enable terms, one per output |
| arst_term | output | 1 | Shared asynchronous-reset term |
| spre_term | output | 1 | Shared synchronous-preset term |

## Verification
A configuration write and a change of the array inputs can land in the same cycle. The outputs must then follow the new inputs through the old row contents and switch to the new contents only after the accepting edge. The bench provokes this by driving new inputs and a beat for row 0 together. It samples once before the edge, where the old row must still decide the result, and once after it, where the new row must.

// File: rtl/pal_pkg.sv
package pal_pkg;

  // Number of product terms feeding OR sum k; grows toward the middle outputs.
  function automatic int grp_size(input int k, input int n_out, input int min_t, input int step);
    int lo;
    lo = (k < (n_out - 1 - k)) ? k : (n_out - 1 - k);
    return min_t + step * lo;
  endfunction

  // First row index of OR group k.
  function automatic int grp_base(input int k, input int n_out, input int min_t, input int step);
    int b;
    b = 0;
    for (int j = 0; j < k; j++) b += grp_size(j, n_out, min_t, step);
    return b;
  endfunction

endpackage

// File: rtl/pal_cfg_store.sv
module pal_cfg_store #(
  parameter int ROWS = 132,
  parameter int COLS = 44,
  parameter int AW   = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_valid,
  input  logic [AW-1:0]             wr_addr,
  input  logic [COLS-1:0]           wr_mask,
  input  logic                      wr_term_en,
  output logic [ROWS-1:0][COLS-1:0] mask_q,
  output logic [ROWS-1:0]           en_q
);

  logic addr_ok;
  assign addr_ok = (int'(wr_addr) < ROWS);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      en_q   <= '0;
    end else if (wr_valid && addr_ok) begin
      mask_q[wr_addr] <= wr_mask;
      en_q[wr_addr]   <= wr_term_en;
    end
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && addr_ok) |=> (mask_q[$past(wr_addr)] == $past(wr_mask) &&
                               en_q[$past(wr_addr)] == $past(wr_term_en))); // R8

  AST_IDLE_OR_BAD_ADDR_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!wr_valid || !addr_ok) |=> ($stable(mask_q) && $stable(en_q))); // R9

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (en_q == '0 && mask_q == '0)); // R10

endmodule

// File: rtl/pal_term_eval.sv
module pal_term_eval #(
  parameter int ROWS = 132,
  parameter int NSIG = 22,
  localparam int COLS = 2 * NSIG
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NSIG-1:0]           sig,
  input  logic [ROWS-1:0][COLS-1:0] mask_q,
  input  logic [ROWS-1:0]           en_q,
  output logic [ROWS-1:0]           term
);

  logic [COLS-1:0] col;

  // Column pairs: even = true, odd = inverted.
  for (genvar i = 0; i < NSIG; i++) begin : g_col
    assign col[2*i]   = sig[i];
    assign col[2*i+1] = ~sig[i];
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    // An unset mask bit lets its column through as a don't-care.
    assign term[r] = en_q[r] & (&(col | ~mask_q[r]));

    logic [NSIG-1:0] pair_hit;
    for (genvar i = 0; i < NSIG; i++) begin : g_pair
      assign pair_hit[i] = mask_q[r][2*i] & mask_q[r][2*i+1];
    end

    AST_CONTRA_LOW: assert property (@(posedge clk) disable iff (rst)
      (|pair_hit) |-> !term[r]); // R3
  end

endmodule

// File: rtl/pal_sop_array.sv
module pal_sop_array #(
  parameter int N_DED = 12,
  parameter int N_OUT = 10,
  parameter int MIN_T = 8,
  parameter int STEP  = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_DED-1:0]       ded_in,
  input  logic [N_OUT-1:0]       fb_in,
  input  logic                   cfg_valid,
  output logic                   cfg_ready,
  input  logic [7:0]             cfg_addr,
  input  logic [2*(N_DED+N_OUT)-1:0] cfg_mask,
  input  logic                   cfg_term_en,
  output logic [N_OUT-1:0]       sum_out,
  output logic [N_OUT-1:0]       oe_out,
  output logic                   arst_term,
  output logic                   spre_term
);
  import pal_pkg::*;

  localparam int NSIG   = N_DED + N_OUT;
  localparam int COLS   = 2 * NSIG;
  localparam int NSUM   = grp_base(N_OUT, N_OUT, MIN_T, STEP);
  localparam int OE_ROW = NSUM;
  localparam int AR_ROW = NSUM + N_OUT;
  localparam int SP_ROW = AR_ROW + 1;
  localparam int ROWS   = SP_ROW + 1;

  logic [ROWS-1:0][COLS-1:0] mask_q;
  logic [ROWS-1:0]           en_q;
  logic [ROWS-1:0]           term;
  logic [NSIG-1:0]           sig;

  assign cfg_ready = ~rst;
  assign sig       = {fb_in, ded_in};

  pal_cfg_store #(.ROWS(ROWS), .COLS(COLS), .AW(8)) u_store (
    .clk        (clk),
    .rst        (rst),
    .wr_valid   (cfg_valid & cfg_ready),
    .wr_addr    (cfg_addr),
    .wr_mask    (cfg_mask),
    .wr_term_en (cfg_term_en),
    .mask_q     (mask_q),
    .en_q       (en_q)
  );

  pal_term_eval #(.ROWS(ROWS), .NSIG(NSIG)) u_eval (
    .clk    (clk),
    .rst    (rst),
    .sig    (sig),
    .mask_q (mask_q),
    .en_q   (en_q),
    .term   (term)
  );

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    localparam int B = grp_base(k, N_OUT, MIN_T, STEP);
    localparam int S = grp_size(k, N_OUT, MIN_T, STEP);
    assign sum_out[k] = |term[B +: S];
    assign oe_out[k]  = term[OE_ROW + k];
  end

  assign arst_term = term[AR_ROW];
  assign spre_term = term[SP_ROW];

  AST_NO_TERM_NO_OUTPUT: assert property (@(posedge clk) disable iff (rst)
    (term == '0) |-> (sum_out == '0 && oe_out == '0 && !arst_term && !spre_term)); // R5

  AST_READY_OUTSIDE_RESET: assert property (@(posedge clk) disable iff (rst)
    cfg_ready); // R10

endmodule

// File: tb/pal_sop_array_tb.sv
module pal_sop_array_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] ded_in = '0;
  logic [9:0]  fb_in = '0;
  logic        cfg_valid = 1'b0;
  logic        cfg_ready;
  logic [7:0]  cfg_addr = '0;
  logic [43:0] cfg_mask = '0;
  logic        cfg_term_en = 1'b0;
  logic [9:0]  sum_out;
  logic [9:0]  oe_out;
  logic        arst_term;
  logic        spre_term;

  int n_chk = 0;
  int n_bad = 0;

  logic [43:0] m_mask [132];
  logic        m_en   [132];

  always #2 clk = ~clk;

  pal_sop_array u_dut (
    .clk(clk), .rst(rst), .ded_in(ded_in), .fb_in(fb_in),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_addr(cfg_addr),
    .cfg_mask(cfg_mask), .cfg_term_en(cfg_term_en),
    .sum_out(sum_out), .oe_out(oe_out), .arst_term(arst_term), .spre_term(spre_term)
  );

  function automatic int sz(input int k);
    int lo;
    lo = (k < 9 - k) ? k : 9 - k;
    return 8 + 2 * lo;
  endfunction

  function automatic int bs(input int k);
    int b;
    b = 0;
    for (int j = 0; j < k; j++) b += sz(j);
    return b;
  endfunction

  function automatic logic mdl_term(input int r);
    logic [43:0] col;
    logic s;
    for (int i = 0; i < 22; i++) begin
      s = (i < 12) ? ded_in[i] : fb_in[i-12];
      col[2*i]   = s;
      col[2*i+1] = ~s;
    end
    return m_en[r] && ((col | ~m_mask[r]) == {44{1'b1}});
  endfunction

  function automatic logic [21:0] mdl_out();
    logic [9:0] s;
    logic [9:0] o;
    for (int k = 0; k < 10; k++) begin
      s[k] = 1'b0;
      for (int r = bs(k); r < bs(k) + sz(k); r++) s[k] |= mdl_term(r);
      o[k] = mdl_term(120 + k);
    end
    return {s, o, mdl_term(130), mdl_term(131)};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(input string req);
    #1;
    check(req, {42'd0, sum_out, oe_out, arst_term, spre_term}, {42'd0, mdl_out()});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    cfg_valid = 1'b0;
    for (int r = 0; r < 132; r++) begin
      m_mask[r] = '0;
      m_en[r]   = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic write_row(input int addr, input logic [43:0] mask, input logic en);
    @(negedge clk);
    cfg_valid   = 1'b1;
    cfg_addr    = 8'(addr);
    cfg_mask    = mask;
    cfg_term_en = en;
    @(negedge clk);
    cfg_valid = 1'b0;
    if (addr < 132) begin
      m_mask[addr] = mask;
      m_en[addr]   = en;
    end
  endtask

  task automatic set_in(input logic [11:0] d, input logic [9:0] f);
    @(negedge clk);
    ded_in = d;
    fb_in  = f;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    #1 check("R10 ready low in reset", {63'd0, cfg_ready}, 64'd0);
    do_reset();
    ded_in = 12'hFFF;
    fb_in  = 10'h3FF;
    #1 check("R10 ready after reset", {63'd0, cfg_ready}, 64'd1);
    check_all("R10 outputs clear");
  endtask

  task automatic t_empty_term();
    do_reset();
    write_row(0, '0, 1'b1);
    #1 check("R2 empty row drives sum0", {54'd0, sum_out}, 64'd1);
  endtask

  task automatic t_and_plane();
    logic [43:0] m;
    do_reset();
    m = '0;
    m[0]  = 1'b1;  // ded 0 true
    m[3]  = 1'b1;  // ded 1 inverted
    m[30] = 1'b1;  // fb 3 true (signal 15)
    write_row(8, m, 1'b1);
    set_in(12'h001, 10'h008); check_all("R1 match");
    #0 check("R1 sum1 high", {54'd0, sum_out}, 64'd2);
    set_in(12'h003, 10'h008); check_all("R1 inverted column blocks");
    set_in(12'h001, 10'h000); check_all("R1 feedback column blocks");
    set_in(12'hFFD, 10'h3FF); check_all("R1 don't-care columns");
    set_in(12'h000, 10'h3FF); check_all("R1 true column blocks");
  endtask

  task automatic t_contra();
    logic [43:0] m;
    do_reset();
    m = '0;
    m[8] = 1'b1;
    m[9] = 1'b1;
    write_row(18, m, 1'b1);
    set_in(12'h010, 10'h000); check_all("R3 signal high");
    #0 check("R3 sum2 low high-in", {54'd0, sum_out}, 64'd0);
    set_in(12'h000, 10'h3FF); check_all("R3 signal low");
    #0 check("R3 sum2 low low-in", {54'd0, sum_out}, 64'd0);
  endtask

  task automatic t_disabled();
    do_reset();
    write_row(40, '0, 1'b0);
    write_row(125, '0, 1'b0);
    set_in(12'hABC, 10'h155); check_all("R4 disabled rows");
    #0 check("R4 outputs low", {42'd0, sum_out, oe_out, arst_term, spre_term}, 64'd0);
    write_row(40, '0, 1'b1);
    write_row(40, '0, 1'b0);
    check_all("R8 overwrite to disabled");
  endtask

  task automatic t_groups();
    for (int k = 0; k < 10; k++) begin
      do_reset();
      write_row(bs(k) + sz(k) - 1, '0, 1'b1);
      #1 check($sformatf("R5 last row of group %0d", k), {54'd0, sum_out}, 64'(1 << k));
      do_reset();
      write_row(bs(k), '0, 1'b1);
      #1 check($sformatf("R5 first row of group %0d", k), {54'd0, sum_out}, 64'(1 << k));
    end
  endtask

  task automatic t_oe();
    for (int k = 0; k < 10; k += 3) begin
      do_reset();
      write_row(120 + k, '0, 1'b1);
      #1 check($sformatf("R6 oe row %0d", k), {44'd0, sum_out, oe_out},
               64'(1 << k));
    end
  endtask

  task automatic t_globals();
    do_reset();
    write_row(130, '0, 1'b1);
    #1 check("R7 arst only", {42'd0, sum_out, oe_out, arst_term, spre_term}, 64'd2);
    write_row(131, '0, 1'b1);
    #1 check("R7 both globals", {42'd0, sum_out, oe_out, arst_term, spre_term}, 64'd3);
  endtask

  task automatic t_bad_addr();
    do_reset();
    write_row(132, '0, 1'b1);
    write_row(200, '0, 1'b1);
    write_row(255, '0, 1'b1);
    #1 check("R9 out-of-range beats", {42'd0, sum_out, oe_out, arst_term, spre_term}, 64'd0);
  endtask

  task automatic t_same_cycle();
    logic [43:0] m;
    do_reset();
    m = '0;
    m[1] = 1'b1;  // ded 0 inverted
    write_row(0, m, 1'b1);
    @(negedge clk);
    ded_in      = 12'h001;
    cfg_valid   = 1'b1;
    cfg_addr    = 8'd0;
    cfg_mask    = 44'd1;   // ded 0 true
    cfg_term_en = 1'b1;
    #1 check("R8 old row before edge", {54'd0, sum_out}, 64'd0);
    @(negedge clk);
    cfg_valid = 1'b0;
    m_mask[0] = 44'd1;
    #1 check("R8 new row after edge", {54'd0, sum_out}, 64'd1);
    set_in(12'h000, 10'h000); check_all("R8 new row tracks input");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_empty_term();
    t_and_plane();
    t_contra();
    t_disabled();
    t_groups();
    t_oe();
    t_globals();
    t_bad_addr();
    t_same_cycle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule